// File: doc/BRIEF.md
# Touch-Aware Conversion Repeat Scheduler

This block decides when a touchscreen converter front end begins a conversion sequence. It starts a sequence on request. It can then repeat the sequence at one of three fixed intervals, measured in system clocks, or run it only once. Each sequence it launches is a single-cycle start pulse. It waits for the converter's done pulse before it lets the interval counter run.

The block has two modes. In slave mode the interval counts as soon as a sequence finishes. In master mode it counts only while the panel is touched. When the touch is lost, any pending interval is dropped, and the next touch starts a sequence without delay.

Alongside the scheduler, a combinational decoder turns the 4-bit channel address and the single-ended/differential select into plate-switch enables and reference selects. It flags addresses that name no channel. A start that would use such an address is replaced by an error pulse. A separate output powers down the internal reference.

Top module: `conv_repeat_sched`

## Requirements
- R1: The interval code sets the repeat period: 01 gives BASE_PERIOD clocks, 10 gives 2*BASE_PERIOD, and 11 gives 16*BASE_PERIOD (BASE_PERIOD defaults to 1024).
- R2: With interval code 00, the done pulse of the sequence returns the block to idle. No further start follows until a new start request.
- R3: In slave mode with a nonzero code, a start pulse is asserted exactly P clocks after the clock edge that samples seq_done_i high, where P is the period from R1.
- R4: In master mode, counting begins at done only if touch_i is high at that edge. Otherwise the block waits, and start_o rises in the cycle after touch_i is first sampled high.
- R5: In master mode, if touch_i is sampled low while counting, the pending interval is cancelled. No start occurs until touch returns, and then one follows in the next cycle.
- R6: start_o is high for exactly one clock and rises in the cycle after an accepted start_req_i. Between a start and the next seq_done_i no other start occurs, and start_req_i is ignored whenever the block is not idle.
- R7: Channel addresses 11 to 15 are invalid. A start attempted with such an address pulses chan_err_o for one cycle instead of start_o, and the block returns to idle.
- R8: A change of interval code or mode while counting restarts the count from zero at the edge that samples the change. A change to code 00 stops the schedule with no further start.
- R9: plate_sw_o is {Y-, Y+, X-, X+}. Address 0 gives 4'b1100, address 1 gives 4'b0011, addresses 2 and 10 give 4'b0110, and every other address gives 4'b0000.
- R10: refp_sel_o uses 0 for VREF, 1 for the Y+ plate and 2 for the X+ plate. refn_sel_o uses 0 for ground, 1 for the Y- plate and 2 for the X- plate. In single-ended mode (diff_mode_i=0), and for non-touch or invalid addresses, both selects are 0. In differential mode, address 0 selects 1/1, address 1 selects 2/2, and addresses 2 and 10 select 1/2.
- R11: int_ref_pd_o is high whenever ext_ref_i is high, regardless of pm_ref_off_i. Otherwise it follows pm_ref_off_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval_sel_i | input | 2 | Repeat interval code |
| master_mode_i | input | 1 | 1 selects touch-gated master mode |
| touch_i | input | 1 | Panel touched |
| start_req_i | input | 1 | Request to begin a schedule |
| seq_done_i | input | 1 | Converter finished the current sequence |
| chan_addr_i | input | 4 | Channel address |
| diff_mode_i | input | 1 | 1 selects differential references |
| ext_ref_i | input | 1 | External reference in use |
| pm_ref_off_i | input | 1 | Power management asks reference off |
| start_o | output | 1 | One-cycle conversion start |
| chan_err_o | output | 1 | One-cycle invalid-address error |
| plate_sw_o | output | 4 | Plate switch enables {Y-,Y+,X-,X+} |
| refp_sel_o | output | 2 | Positive reference select |
| refn_sel_o | output | 2 | Negative reference select |
| int_ref_pd_o | output | 1 | Internal reference power-down |

## Verification
The hardest situations to reach are the ones that interrupt a running interval: touch lost part way through a master-mode count, a configuration rewrite mid-count, and an address that turns invalid before the interval expires. The stimulus notes the cycle in which it drives each done pulse. It then drops the touch, rewrites the interval code or corrupts the address a known number of cycles later, well before the expiry. Each expected start or error is queued with the exact cycle that the R3 timing rule predicts, so a pulse that arrives early or late, or a leftover pulse from a cancelled count, is caught.

// File: rtl/crs_pkg.sv
// Shared definitions for the conversion repeat scheduler.
// Assumes a 4-bit channel address space with 11 valid channels.
package crs_pkg;
    localparam int CH_ADDR_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_COUNT = 2'd2,
        ST_WAIT  = 2'd3
    } sched_st_t;

    localparam logic [1:0] REFP_VREF = 2'd0;
    localparam logic [1:0] REFP_YPOS = 2'd1;
    localparam logic [1:0] REFP_XPOS = 2'd2;
    localparam logic [1:0] REFN_GND  = 2'd0;
    localparam logic [1:0] REFN_YNEG = 2'd1;
    localparam logic [1:0] REFN_XNEG = 2'd2;

    // Plate switch bit positions in plate_sw_o
    localparam int SW_XP = 0;
    localparam int SW_XN = 1;
    localparam int SW_YP = 2;
    localparam int SW_YN = 3;
endpackage

// File: rtl/plate_decode.sv
// Channel address decoder: maps an address and the reference mode onto
// plate switch enables, reference selects and an invalid-address flag.
// Purely combinational; assumes the address is stable while it is used.
module plate_decode
    import crs_pkg::*;
(
    input  logic [CH_ADDR_W-1:0] addr_i,
    input  logic                 diff_i,
    output logic [3:0]           plate_sw_o,
    output logic [1:0]           refp_o,
    output logic [1:0]           refn_o,
    output logic                 addr_bad_o
);
    logic [1:0] dp, dn;

    // Decode switch pattern and the differential reference pair per channel
    always_comb begin
        plate_sw_o = 4'b0000;
        dp         = REFP_VREF;
        dn         = REFN_GND;
        addr_bad_o = 1'b0;
        case (addr_i)
            4'd0: begin
                plate_sw_o[SW_YP] = 1'b1;
                plate_sw_o[SW_YN] = 1'b1;
                dp = REFP_YPOS;
                dn = REFN_YNEG;
            end
            4'd1: begin
                plate_sw_o[SW_XP] = 1'b1;
                plate_sw_o[SW_XN] = 1'b1;
                dp = REFP_XPOS;
                dn = REFN_XNEG;
            end
            4'd2, 4'd10: begin
                plate_sw_o[SW_XN] = 1'b1;
                plate_sw_o[SW_YP] = 1'b1;
                dp = REFP_YPOS;
                dn = REFN_XNEG;
            end
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: ;
            default: addr_bad_o = 1'b1;
        endcase
    end

    // Single-ended mode always refers to VREF and ground
    always_comb begin
        refp_o = diff_i ? dp : REFP_VREF;
        refn_o = diff_i ? dn : REFN_GND;
    end
endmodule

// File: rtl/repeat_timer.sv
// Interval counter: counts clocks while run_i is high and flags the last
// cycle of the selected period. Held at zero while stopped or cleared.
// Assumes sel_i is nonzero whenever run_i is high.
module repeat_timer #(
    parameter int BASE_PERIOD = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clear_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);
    localparam int MAX_PERIOD = 16 * BASE_PERIOD;
    localparam int CNT_W      = $clog2(MAX_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected interval code
    always_comb begin
        case (sel_i)
            2'b01:   limit = CNT_W'(BASE_PERIOD - 1);
            2'b10:   limit = CNT_W'(2 * BASE_PERIOD - 1);
            2'b11:   limit = CNT_W'(MAX_PERIOD - 1);
            default: limit = '1;
        endcase
    end

    assign expire_o = run_i && !clear_i && (cnt_q == limit);

    // Advance the count, wrapping on expiry and parking at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !run_i || expire_o) cnt_q <= '0;
        else                                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/conv_repeat_sched.sv
// Conversion repeat scheduler top: launches one-cycle start pulses on
// request and then once or periodically, gated by touch in master mode.
// Assumes seq_done_i pulses once per launched sequence.
module conv_repeat_sched
    import crs_pkg::*;
#(
    parameter int BASE_PERIOD = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           interval_sel_i,
    input  logic                 master_mode_i,
    input  logic                 touch_i,
    input  logic                 start_req_i,
    input  logic                 seq_done_i,
    input  logic [CH_ADDR_W-1:0] chan_addr_i,
    input  logic                 diff_mode_i,
    input  logic                 ext_ref_i,
    input  logic                 pm_ref_off_i,
    output logic                 start_o,
    output logic                 chan_err_o,
    output logic [3:0]           plate_sw_o,
    output logic [1:0]           refp_sel_o,
    output logic [1:0]           refn_sel_o,
    output logic                 int_ref_pd_o
);
    sched_st_t  st_q, st_d;
    logic [2:0] cfg_q;
    logic       cfg_change, launch, run, clear, expire, addr_bad;

    plate_decode u_dec (
        .addr_i     (chan_addr_i),
        .diff_i     (diff_mode_i),
        .plate_sw_o (plate_sw_o),
        .refp_o     (refp_sel_o),
        .refn_o     (refn_sel_o),
        .addr_bad_o (addr_bad)
    );

    repeat_timer #(.BASE_PERIOD(BASE_PERIOD)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .clear_i  (clear),
        .sel_i    (interval_sel_i),
        .expire_o (expire)
    );

    assign cfg_change   = ({interval_sel_i, master_mode_i} != cfg_q);
    assign int_ref_pd_o = ext_ref_i | pm_ref_off_i;

    // Next-state logic: decide when to launch, count, wait or stop
    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        run    = 1'b0;
        clear  = 1'b0;
        case (st_q)
            ST_IDLE: launch = start_req_i;
            ST_BUSY: if (seq_done_i) begin
                if (interval_sel_i == 2'b00)       st_d = ST_IDLE;
                else if (!master_mode_i || touch_i) st_d = ST_COUNT;
                else                                st_d = ST_WAIT;
            end
            ST_COUNT: begin
                run = 1'b1;
                if (cfg_change) begin
                    clear = 1'b1;
                    if (interval_sel_i == 2'b00) st_d = ST_IDLE;
                end else if (master_mode_i && !touch_i) begin
                    clear = 1'b1;
                    st_d  = ST_WAIT;
                end else if (expire) begin
                    launch = 1'b1;
                end
            end
            ST_WAIT: begin
                if (interval_sel_i == 2'b00) st_d = ST_IDLE;
                else if (!master_mode_i)     st_d = ST_COUNT;
                else if (touch_i)            launch = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
        if (launch) st_d = addr_bad ? ST_IDLE : ST_BUSY;
    end

    // State, configuration snapshot and registered pulse outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cfg_q      <= 3'b000;
            start_o    <= 1'b0;
            chan_err_o <= 1'b0;
        end else begin
            st_q       <= st_d;
            cfg_q      <= {interval_sel_i, master_mode_i};
            start_o    <= launch && !addr_bad;
            chan_err_o <= launch && addr_bad;
        end
    end

    // R6
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R6
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && !seq_done_i) |=> !start_o);
    // R7
    err_excludes_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err_o |-> (!start_o && $past(addr_bad)));
    // R2
    once_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && seq_done_i && interval_sel_i == 2'b00) |=> (st_q == ST_IDLE));
    // R5
    release_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT && master_mode_i && !touch_i) |=> !start_o);
endmodule

// File: tb/test_conv_repeat_sched.sv
module test_conv_repeat_sched;
    localparam int BP = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] interval_sel = 2'b00;
    logic master = 1'b0, touch = 1'b0, start_req = 1'b0, seq_done = 1'b0;
    logic [3:0] chan = 4'd3;
    logic diff = 1'b0, ext_ref = 1'b0, pm_off = 1'b0;
    logic start_o, chan_err_o, int_ref_pd_o;
    logic [3:0] plate_sw_o;
    logic [1:0] refp_sel_o, refn_sel_o;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int    at;
        bit    is_err;
        string tag;
    } ev_t;
    ev_t expq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_repeat_sched #(.BASE_PERIOD(BP)) i_conv_repeat_sched (
        .clk(clk), .rst_n(rst_n), .interval_sel_i(interval_sel),
        .master_mode_i(master), .touch_i(touch), .start_req_i(start_req),
        .seq_done_i(seq_done), .chan_addr_i(chan), .diff_mode_i(diff),
        .ext_ref_i(ext_ref), .pm_ref_off_i(pm_off), .start_o(start_o),
        .chan_err_o(chan_err_o), .plate_sw_o(plate_sw_o),
        .refp_sel_o(refp_sel_o), .refn_sel_o(refn_sel_o),
        .int_ref_pd_o(int_ref_pd_o));

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(int at, bit is_err, string tag);
        ev_t e;
        e.at = at; e.is_err = is_err; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Request a start; returns the drive cycle
    task automatic request(output int c);
        @(negedge clk); start_req = 1'b1; c = cyc;
        @(negedge clk); start_req = 1'b0;
    endtask

    // Pulse done; returns the drive cycle
    task automatic done_pulse(output int c);
        @(negedge clk); seq_done = 1'b1; c = cyc;
        @(negedge clk); seq_done = 1'b0;
    endtask

    // Monitor: every start or error pulse must match the next queued event
    always @(negedge clk) begin
        if (rst_n && (start_o || chan_err_o)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R6 unexpected pulse", cyc, -1);
            end else begin
                ev_t e;
                e = expq.pop_front();
                chk(e.at == cyc, {e.tag, " pulse cycle"}, cyc, e.at);
                chk(chan_err_o == e.is_err && start_o == !e.is_err,
                    {e.tag, " pulse kind (1=err)"}, int'(chan_err_o), int'(e.is_err));
            end
        end
    end

    // Reference model for the decoder (R9, R10, R7)
    function automatic logic [8:0] model_dec(int a, bit d);
        logic [3:0] sw; logic [1:0] p, n; logic bad;
        sw = 4'b0000; p = 2'd0; n = 2'd0; bad = (a > 10);
        if (a == 0)                 begin sw = 4'b1100; if (d) begin p = 2'd1; n = 2'd1; end end
        else if (a == 1)            begin sw = 4'b0011; if (d) begin p = 2'd2; n = 2'd2; end end
        else if (a == 2 || a == 10) begin sw = 4'b0110; if (d) begin p = 2'd1; n = 2'd2; end end
        return {bad, sw, p, n};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c, d, m;
        logic [8:0] exp_dec;
        wait_cyc(4);
        chk(start_o == 1'b0, "R6 reset start_o", int'(start_o), 0);
        chk(chan_err_o == 1'b0, "R7 reset chan_err_o", int'(chan_err_o), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);

        // Decoder sweep: R9 switches, R10 references, R7 invalid codes
        for (int dm = 0; dm < 2; dm++) begin
            for (int a = 0; a < 16; a++) begin
                @(negedge clk); chan = 4'(a); diff = dm[0];
                #1;
                exp_dec = model_dec(a, dm[0]);
                chk(plate_sw_o == exp_dec[7:4], "R9 plate switches", int'(plate_sw_o), int'(exp_dec[7:4]));
                chk({refp_sel_o, refn_sel_o} == exp_dec[3:0], "R10 reference selects",
                    int'({refp_sel_o, refn_sel_o}), int'(exp_dec[3:0]));
            end
        end
        @(negedge clk); chan = 4'd3; diff = 1'b0;

        // R11: external reference overrides power management
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ext_ref = k[1]; pm_off = k[0];
            #1;
            chk(int_ref_pd_o == (k[1] | k[0]), "R11 reference power-down", int'(int_ref_pd_o), int'(k[1] | k[0]));
        end

        // R2 once-only, plus R6 request ignored while busy
        interval_sel = 2'b00; master = 1'b0;
        request(c); push(c + 1, 1'b0, "R6 first start");
        wait_cyc(3);
        request(c);   // ignored: busy
        wait_cyc(3);
        done_pulse(d);
        wait_cyc(600);   // R2: no start expected

        // R1/R3 slave periodic with code 01
        @(negedge clk); interval_sel = 2'b01;
        wait_cyc(2);
        request(c); push(c + 1, 1'b0, "R6 start latency");
        wait_cyc(2);
        done_pulse(d); push(d + 1 + BP, 1'b0, "R3 period 01");
        wait_cyc(BP + 5);
        done_pulse(d); push(d + 1 + BP, 1'b0, "R1 period 01 repeat");
        wait_cyc(BP + 5);
        // R1 code 11
        @(negedge clk); interval_sel = 2'b11;
        done_pulse(d); push(d + 1 + 16 * BP, 1'b0, "R1 period 11");
        wait_cyc(16 * BP + 5);
        // R8 change 10 -> 01 while counting
        @(negedge clk); interval_sel = 2'b10;
        done_pulse(d);
        wait_cyc(10);
        @(negedge clk); interval_sel = 2'b01; m = cyc;
        push(m + 1 + BP, 1'b0, "R8 restart after change");
        wait_cyc(BP + 5);
        // R8 change to 00 while counting stops the schedule
        done_pulse(d);
        wait_cyc(5);
        @(negedge clk); interval_sel = 2'b00;
        wait_cyc(3 * BP);
        // R7 address turns invalid during the count
        @(negedge clk); interval_sel = 2'b01;
        wait_cyc(2);
        request(c); push(c + 1, 1'b0, "R6 start before bad addr");
        wait_cyc(2);
        done_pulse(d); push(d + 1 + BP, 1'b1, "R7 invalid at expiry");
        wait_cyc(5);
        @(negedge clk); chan = 4'd13;
        wait_cyc(BP + 20);
        // R7 invalid address on request from idle
        @(negedge clk); chan = 4'd15;
        request(c); push(c + 1, 1'b1, "R7 invalid request");
        wait_cyc(BP + 10);
        @(negedge clk); chan = 4'd0;

        // R4 master mode
        @(negedge clk); master = 1'b1; touch = 1'b1;
        wait_cyc(2);
        request(c); push(c + 1, 1'b0, "R4 master start");
        wait_cyc(2);
        done_pulse(d); push(d + 1 + BP, 1'b0, "R4 touched at done");
        wait_cyc(BP + 5);
        @(negedge clk); touch = 1'b0;
        done_pulse(d);
        wait_cyc(3 * BP);   // R4: waiting for touch, no start
        @(negedge clk); touch = 1'b1; c = cyc;
        push(c + 1, 1'b0, "R4 touch triggers start");
        wait_cyc(3);
        // R5 release mid-count, retouch gives immediate start
        done_pulse(d);
        wait_cyc(5);
        @(negedge clk); touch = 1'b0;
        wait_cyc(5);
        @(negedge clk); touch = 1'b1; c = cyc;
        push(c + 1, 1'b0, "R5 retouch immediate");
        wait_cyc(3);
        done_pulse(d); push(d + 1 + BP, 1'b0, "R5 normal count resumes");
        wait_cyc(BP + 5);
        @(negedge clk); interval_sel = 2'b00;
        done_pulse(d);
        wait_cyc(3 * BP);

        chk(expq.size() == 0, "R6 all expected pulses seen", expq.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule